// File: doc/BRIEF.md
# Diagonal Mesh Route Computation

This block computes the output port for one tile of a two-dimensional mesh whose tiles are linked to all eight compass neighbours. Given the tile's own x,y position and a packet's destination, it raises exactly one bit of a nine-bit port request: one bit per neighbour direction and one for the local core. The logic is purely combinational. A router's switch allocator uses the result in the same cycle.

When the packet still has to travel on both axes, the block takes the diagonal that shortens both offsets in a single hop. It falls back to a straight move only once one axis is already aligned. The destination can be given as coordinates or as a row-major tile number, which the block converts itself. The block never names a port that has no neighbour behind it on a corner or border tile. Coordinates or tile numbers outside the mesh raise an error flag and produce no request. The mesh width and height are parameters; 4x4 and 8x8 meshes are both supported.

Top module: `diag_mesh_route`

## Requirements
- R1: When the destination equals the current tile, only bit 0 (Local) of `port_req` is set.
- R2: When both the x and y offsets are nonzero, the diagonal that matches their signs is requested: NE is bit 2, SE bit 4, SW bit 6 and NW bit 8, where north means increasing y and east means increasing x.
- R3: When only the x offset is nonzero, E (bit 3) is requested for a larger destination x and W (bit 7) for a smaller one.
- R4: When only the y offset is nonzero, N (bit 1) is requested for a larger destination y and S (bit 5) for a smaller one.
- R5: For any valid input, `port_req` has exactly one bit set and `route_err` is 0.
- R6: The requested neighbour always lies inside the mesh. A corner tile has three neighbours, a border tile has five and an interior tile has eight.
- R7: With `dst_by_id`=1, the destination is taken from `dst_id` as x = id mod MESH_W and y = id div MESH_W, and `dst_x`/`dst_y` have no effect. With `dst_by_id`=0, `dst_id` has no effect.
- R8: A destination outside the mesh (x >= MESH_W, y >= MESH_H, or an ID >= MESH_W*MESH_H) sets `route_err` and forces `port_req` to all zeros.
- R9: A current tile coordinate outside the mesh sets `route_err` and forces `port_req` to all zeros.
- R10: The same code routes correctly when configured as an 8x8 mesh and as a 4x4 mesh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cur_x | input | CW | x coordinate of this tile |
| cur_y | input | CW | y coordinate of this tile |
| dst_by_id | input | 1 | 1: destination from dst_id; 0: from dst_x/dst_y |
| dst_x | input | CW | destination x coordinate |
| dst_y | input | CW | destination y coordinate |
| dst_id | input | IW | destination tile number, row-major |
| port_req | output | 9 | one-hot request: Local, N, NE, E, SE, S, SW, W, NW from bit 0 up |
| route_err | output | 1 | destination or current tile outside the mesh |

## Verification
The bench sweeps every pair of current and destination tiles in both mesh sizes, so it covers the corners and edges where an unmasked diagonal would point off the mesh. A design with a swapped sign test would send a packet away from its destination. A design without diagonal priority would pick E or N where a diagonal is due. Directed vectors give IDs at and beyond the last tile, and coordinates one past the edge. A design with a faulty range check would emit a request with no error flag. A design with a wrong ID split would route to the mirrored tile, and a design with a broken source select would let the unused destination input steer the route.

// File: rtl/dmr_pkg.sv
package dmr_pkg;

   localparam int NPORT = 9;

   typedef enum int {
      P_LOCAL = 0,
      P_N     = 1,
      P_NE    = 2,
      P_E     = 3,
      P_SE    = 4,
      P_S     = 5,
      P_SW    = 6,
      P_W     = 7,
      P_NW    = 8
   } port_e;

   typedef logic [NPORT-1:0] port_vec_t;

   function automatic int port_step_x(int p);
      case (p)
         P_NE, P_E, P_SE: return 1;
         P_SW, P_W, P_NW: return -1;
         default:         return 0;
      endcase
   endfunction

   function automatic int port_step_y(int p);
      case (p)
         P_N, P_NE, P_NW: return 1;
         P_SE, P_S, P_SW: return -1;
         default:         return 0;
      endcase
   endfunction

endpackage

// File: rtl/dmr_id_decode.sv
module dmr_id_decode #(
   parameter int MESH_W = 8,
   parameter int MESH_H = 8,
   parameter int CW     = 4,
   parameter int IW     = 8
) (
   input  logic [IW-1:0] id,
   output logic [CW-1:0] x,
   output logic [CW-1:0] y,
   output logic          in_range
);
   localparam int CELLS   = MESH_W * MESH_H;
   localparam int XLOG    = $clog2(MESH_W);
   localparam bit W_POW2  = ((1 << XLOG) == MESH_W);

   initial begin
      if ((1 << IW) <= CELLS) $error("IW too narrow for mesh tile count");
   end

   int id_v;
   assign id_v     = int'(id);
   assign in_range = (id_v < CELLS);

   generate
      if (W_POW2) begin : g_shift
         always_comb begin
            x = CW'(id_v & (MESH_W - 1));
            y = CW'(id_v >> XLOG);
         end
      end else begin : g_divide
         always_comb begin
            x = CW'(id_v % MESH_W);
            y = CW'(id_v / MESH_W);
         end
      end
   endgenerate

   always_comb begin
      if (in_range) begin
         assert_id_rowmajor_R7: assert ((int'(y) * MESH_W + int'(x)) == id_v)
            else $error("tile number split does not recombine");
      end
   end

endmodule

// File: rtl/dmr_dir_select.sv
module dmr_dir_select
   import dmr_pkg::*;
#(
   parameter int CW = 4
) (
   input  logic [CW-1:0] cur_x,
   input  logic [CW-1:0] cur_y,
   input  logic [CW-1:0] dst_x,
   input  logic [CW-1:0] dst_y,
   output port_vec_t     dir
);
   logic go_e, go_w, go_n, go_s;

   assign go_e = (dst_x > cur_x);
   assign go_w = (dst_x < cur_x);
   assign go_n = (dst_y > cur_y);
   assign go_s = (dst_y < cur_y);

   always_comb begin
      dir = '0;
      unique case ({go_e, go_w, go_n, go_s})
         4'b1010: dir[P_NE]    = 1'b1;
         4'b1001: dir[P_SE]    = 1'b1;
         4'b0110: dir[P_NW]    = 1'b1;
         4'b0101: dir[P_SW]    = 1'b1;
         4'b1000: dir[P_E]     = 1'b1;
         4'b0100: dir[P_W]     = 1'b1;
         4'b0010: dir[P_N]     = 1'b1;
         4'b0001: dir[P_S]     = 1'b1;
         default: dir[P_LOCAL] = 1'b1;
      endcase
   end

   always_comb begin
      assert_dir_onehot_R5: assert ($onehot(dir))
         else $error("direction vector not one-hot");
      assert_local_iff_home_R1: assert (dir[P_LOCAL] == ((cur_x == dst_x) && (cur_y == dst_y)))
         else $error("local port disagrees with coordinate match");
      if ((cur_x != dst_x) && (cur_y != dst_y)) begin
         assert_diag_first_R2: assert ((dir[P_NE] | dir[P_SE] | dir[P_SW] | dir[P_NW]) == 1'b1)
            else $error("two-axis offset without diagonal");
      end
   end

endmodule

// File: rtl/dmr_edge_mask.sv
module dmr_edge_mask
   import dmr_pkg::*;
#(
   parameter int MESH_W = 8,
   parameter int MESH_H = 8,
   parameter int CW     = 4
) (
   input  logic [CW-1:0] cur_x,
   input  logic [CW-1:0] cur_y,
   output port_vec_t     present
);
   int xv, yv;
   assign xv = int'(cur_x);
   assign yv = int'(cur_y);

   genvar g;
   generate
      for (g = 0; g < NPORT; g++) begin : g_port
         localparam int SX = port_step_x(g);
         localparam int SY = port_step_y(g);
         logic ok_x, ok_y;
         assign ok_x = (SX == 0) || ((SX > 0) ? (xv < MESH_W - 1) : (xv > 0));
         assign ok_y = (SY == 0) || ((SY > 0) ? (yv < MESH_H - 1) : (yv > 0));
         assign present[g] = ok_x && ok_y;
      end
   endgenerate

   always_comb begin
      if ((xv < MESH_W) && (yv < MESH_H)) begin
         assert_neighbour_count_R6: assert (($countones(present) == 4) ||
                                            ($countones(present) == 6) ||
                                            ($countones(present) == 9))
            else $error("neighbour count not 3, 5 or 8");
      end
   end

endmodule

// File: rtl/diag_mesh_route.sv
module diag_mesh_route
   import dmr_pkg::*;
#(
   parameter int MESH_W = 8,
   parameter int MESH_H = 8,
   parameter int CW     = 4,
   parameter int IW     = 8
) (
   input  logic [CW-1:0] cur_x,
   input  logic [CW-1:0] cur_y,
   input  logic          dst_by_id,
   input  logic [CW-1:0] dst_x,
   input  logic [CW-1:0] dst_y,
   input  logic [IW-1:0] dst_id,
   output logic [8:0]    port_req,
   output logic          route_err
);
   initial begin
      if (MESH_W < 2 || MESH_H < 2) $error("mesh must be at least 2x2");
      if ((1 << CW) < MESH_W || (1 << CW) < MESH_H) $error("CW too narrow for mesh");
   end

   logic [CW-1:0] id_x, id_y, tgt_x, tgt_y;
   logic          id_ok, tgt_ok, cur_ok;
   port_vec_t     dir, present;

   dmr_id_decode #(.MESH_W(MESH_W), .MESH_H(MESH_H), .CW(CW), .IW(IW)) u_decode (
      .id(dst_id), .x(id_x), .y(id_y), .in_range(id_ok)
   );

   assign tgt_x  = dst_by_id ? id_x : dst_x;
   assign tgt_y  = dst_by_id ? id_y : dst_y;
   assign tgt_ok = dst_by_id ? id_ok
                             : ((int'(dst_x) < MESH_W) && (int'(dst_y) < MESH_H));
   assign cur_ok = (int'(cur_x) < MESH_W) && (int'(cur_y) < MESH_H);

   dmr_dir_select #(.CW(CW)) u_dir (
      .cur_x(cur_x), .cur_y(cur_y), .dst_x(tgt_x), .dst_y(tgt_y), .dir(dir)
   );

   dmr_edge_mask #(.MESH_W(MESH_W), .MESH_H(MESH_H), .CW(CW)) u_mask (
      .cur_x(cur_x), .cur_y(cur_y), .present(present)
   );

   assign route_err = !(cur_ok && tgt_ok);
   assign port_req  = route_err ? '0 : (dir & present);

   always_comb begin
      if (!route_err) begin
         assert_dir_on_mesh_R6: assert ((dir & ~present) == '0)
            else $error("direction points off the mesh");
         assert_req_onehot_R5: assert ($onehot(port_req))
            else $error("valid route without single request");
      end else begin
         assert_err_silent_R8: assert (port_req == '0)
            else $error("request raised with error flag");
      end
   end

endmodule

// File: tb/diag_mesh_route_bench.sv
module diag_mesh_route_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // 8x8 instance
   logic [3:0] cx, cy, dx, dy;
   logic [7:0] did;
   logic       byid;
   logic [8:0] req;
   logic       err;

   diag_mesh_route u_diag_mesh_route (
      .cur_x(cx), .cur_y(cy), .dst_by_id(byid), .dst_x(dx), .dst_y(dy),
      .dst_id(did), .port_req(req), .route_err(err)
   );

   // 4x4 instance
   logic [2:0] cx4, cy4, dx4, dy4;
   logic [4:0] did4;
   logic [8:0] req4;
   logic       err4;

   diag_mesh_route #(.MESH_W(4), .MESH_H(4), .CW(3), .IW(5)) u_diag_mesh_route_4x4 (
      .cur_x(cx4), .cur_y(cy4), .dst_by_id(1'b0), .dst_x(dx4), .dst_y(dy4),
      .dst_id(did4), .port_req(req4), .route_err(err4)
   );

   // {by_id, cur_x, cur_y, dst_x, dst_y, dst_id, exp_req, exp_err}
   localparam logic [34:0] TBL [16] = '{
      {1'b0, 4'd3, 4'd3, 4'd3, 4'd3, 8'd0,  9'h001, 1'b0}, // R1 home
      {1'b0, 4'd3, 4'd3, 4'd4, 4'd4, 8'd0,  9'h004, 1'b0}, // R2 NE
      {1'b0, 4'd3, 4'd3, 4'd2, 4'd2, 8'd0,  9'h040, 1'b0}, // R2 SW
      {1'b0, 4'd3, 4'd3, 4'd5, 4'd1, 8'd0,  9'h010, 1'b0}, // R2 SE
      {1'b0, 4'd3, 4'd3, 4'd0, 4'd7, 8'd0,  9'h100, 1'b0}, // R2 NW
      {1'b0, 4'd3, 4'd3, 4'd7, 4'd3, 8'd0,  9'h008, 1'b0}, // R3 E
      {1'b0, 4'd3, 4'd3, 4'd0, 4'd3, 8'd0,  9'h080, 1'b0}, // R3 W
      {1'b0, 4'd3, 4'd3, 4'd3, 4'd6, 8'd0,  9'h002, 1'b0}, // R4 N
      {1'b0, 4'd3, 4'd3, 4'd3, 4'd0, 8'd0,  9'h020, 1'b0}, // R4 S
      {1'b0, 4'd0, 4'd0, 4'd7, 4'd7, 8'd0,  9'h004, 1'b0}, // R6 corner
      {1'b0, 4'd7, 4'd7, 4'd0, 4'd0, 8'd0,  9'h040, 1'b0}, // R6 corner
      {1'b1, 4'd2, 4'd5, 4'd0, 4'd0, 8'd46, 9'h008, 1'b0}, // R7 id 46 -> (6,5)
      {1'b1, 4'd2, 4'd5, 4'd2, 4'd5, 8'd0,  9'h040, 1'b0}, // R7 id 0, xy ignored
      {1'b1, 4'd2, 4'd5, 4'd2, 4'd5, 8'd64, 9'h000, 1'b1}, // R8 id past end
      {1'b0, 4'd2, 4'd5, 4'd8, 4'd5, 8'd0,  9'h000, 1'b1}, // R8 x past edge
      {1'b0, 4'd9, 4'd1, 4'd1, 4'd1, 8'd0,  9'h000, 1'b1}  // R9 bad current
   };

   localparam string TAG [16] = '{"R1","R2","R2","R2","R2","R3","R3","R4","R4",
                                  "R6","R6","R7","R7","R8","R8","R9"};

   function automatic logic [9:0] ref_route(int w, int h, int x0, int y0, int x1, int y1);
      int sx, sy, bit_i;
      if (x0 >= w || y0 >= h || x1 >= w || y1 >= h) return {1'b1, 9'h000};
      sx = (x1 > x0) ? 1 : (x1 < x0) ? -1 : 0;
      sy = (y1 > y0) ? 1 : (y1 < y0) ? -1 : 0;
      case ({sx, sy})
         {0, 0}:   bit_i = 0;
         {0, 1}:   bit_i = 1;
         {1, 1}:   bit_i = 2;
         {1, 0}:   bit_i = 3;
         {1, -1}:  bit_i = 4;
         {0, -1}:  bit_i = 5;
         {-1, -1}: bit_i = 6;
         {-1, 0}:  bit_i = 7;
         default:  bit_i = 8;
      endcase
      return {1'b0, 9'(1 << bit_i)};
   endfunction

   function automatic string tag_of(int x0, int y0, int x1, int y1);
      if (x0 == x1 && y0 == y1) return "R1";
      if (x0 != x1 && y0 != y1) return "R2";
      if (x0 != x1) return "R3";
      return "R4";
   endfunction

   task automatic check(string tag, logic [9:0] got, logic [9:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got err=%0b req=%h, expected err=%0b req=%h",
                  tag, got[9], got[8:0], exp[9], exp[8:0]);
      end
   endtask

   // neighbour reached by the request must be on the mesh (R6)
   task automatic check_on_mesh(int w, int h, int x0, int y0, logic [8:0] r);
      int nx, ny;
      nx = x0; ny = y0;
      if (r[2] | r[3] | r[4]) nx++;
      if (r[6] | r[7] | r[8]) nx--;
      if (r[1] | r[2] | r[8]) ny++;
      if (r[4] | r[5] | r[6]) ny--;
      checks++;
      if (nx < 0 || ny < 0 || nx >= w || ny >= h || !$onehot(r)) begin
         fails++;
         $display("FAIL R6/R5: tile (%0d,%0d) req=%h reaches (%0d,%0d), expected one port on mesh",
                  x0, y0, r, nx, ny);
      end
   endtask

   task automatic apply8(logic b, int x0, int y0, int x1, int y1, int id);
      @(posedge clk);
      #2;
      byid = b; cx = 4'(x0); cy = 4'(y0); dx = 4'(x1); dy = 4'(y1); did = 8'(id);
      #8;
   endtask

   initial begin
      byid = 0; cx = 0; cy = 0; dx = 0; dy = 0; did = 0;
      cx4 = 0; cy4 = 0; dx4 = 0; dy4 = 0; did4 = 0;
      repeat (3) @(posedge clk);
      #5;
      check("R1 reset state", {err, req}, {1'b0, 9'h001});
      check("R10 reset state 4x4", {err4, req4}, {1'b0, 9'h001});
      rst_n = 1'b1;

      for (int i = 0; i < 16; i++) begin
         apply8(TBL[i][34], int'(TBL[i][33:30]), int'(TBL[i][29:26]),
                int'(TBL[i][25:22]), int'(TBL[i][21:18]), int'(TBL[i][17:10]));
         check(TAG[i], {err, req}, {TBL[i][0], TBL[i][9:1]});
      end

      // R8: y past edge; R7: dst_id ignored when selecting coordinates
      apply8(1'b0, 1, 1, 1, 8, 0);
      check("R8 y past edge", {err, req}, {1'b1, 9'h000});
      apply8(1'b0, 1, 1, 2, 1, 200);
      check("R7 id ignored", {err, req}, {1'b0, 9'h008});
      apply8(1'b1, 0, 0, 0, 0, 63);
      check("R7 last tile", {err, req}, {1'b0, 9'h004});

      // exhaustive 8x8 sweep
      for (int a = 0; a < 64; a++) begin
         for (int b = 0; b < 64; b++) begin
            apply8(1'b0, a % 8, a / 8, b % 8, b / 8, 0);
            check(tag_of(a % 8, a / 8, b % 8, b / 8), {err, req},
                  ref_route(8, 8, a % 8, a / 8, b % 8, b / 8));
            check_on_mesh(8, 8, a % 8, a / 8, req);
         end
      end

      // exhaustive 4x4 sweep (R10), including one-past-edge destinations
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 25; b++) begin
            @(posedge clk);
            #2;
            cx4 = 3'(a % 4); cy4 = 3'(a / 4); dx4 = 3'(b % 5); dy4 = 3'(b / 5);
            #8;
            check("R10 4x4", {err4, req4}, ref_route(4, 4, a % 4, a / 4, b % 5, b / 5));
            if (!err4) check_on_mesh(4, 4, a % 4, a / 4, req4);
         end
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule